// File: doc/BRIEF.md
# Atomic Load-And-Clear Word Unit

This unit carries out a semaphore primitive: it reads a 32-bit word from memory and replaces it with zero in a single indivisible exchange, handing the previous contents back for a register write. A caller presents an instruction word together with the current values of the base and index registers. The unit forms the effective address from either a short signed displacement or an index register (optionally scaled by four), and it may also update the base register before or after the access.

The access address must sit on a 16-byte boundary. A misaligned request never reaches memory. Instead, the unit raises a one-cycle fault pulse and produces no register writes. An aligned request issues a read and then a zero write to the same address. The bus lock stays asserted from the read request until the write is acknowledged, so no other master can slip in between the two halves.

Operands enter through a valid/ready handshake. The operand side is ready only while the unit is idle, and a request is taken on a cycle where both `op_valid` and `op_ready` are high. The result leaves through a second valid/ready pair: once `res_valid` rises, it stays high and every result field holds its value until `res_ready` is seen high on a clock edge. The memory side uses a plain request/acknowledge scheme: `mem_req` and its qualifiers stay steady until `mem_ack` arrives, and `mem_rdata` is valid in the acknowledge cycle of a read.

Top module: `lcw_unit`

## Requirements
- R1: An aligned request returns the word read from memory on `res_dst_val`, and that memory word holds zero once the request completes.
- R2: Each exchange makes exactly one read followed directly by one write of zero to the same address. `mem_lock` is high on every request and stays high from the read request until the write acknowledge.
- R3: When any of the low four bits of the access address are set, no memory request is made and no result is produced. `flt_align` is high for exactly one cycle.
- R4: With instruction bit 12 set, bits 20..16 form a two's-complement displacement, and the offset address is base plus that displacement.
- R5: In displacement mode, bit 5 clear means the access is at base plus displacement with no base update. Bit 5 set with bit 13 set means pre-modify: the access is at base plus displacement and the base becomes that sum. Bit 5 set with bit 13 clear means post-modify: the access is at the old base and the base becomes base plus displacement.
- R6: With bit 12 clear, `op_index` is added to the base, shifted left by two when bit 13 is set. With bit 5 clear the access is at that sum with no update. With bit 5 set the access is at the old base and the base becomes the sum.
- R7: When the base is modified and the destination field (bits 4..0) equals the base field (bits 25..21), the base write is dropped and only the old memory value is written to that register.
- R8: Register 0 is never written: `res_dst_we` is low when bits 4..0 are zero, and `res_base_we` is low when bits 25..21 are zero.
- R9: After reset, `op_ready` is high and `mem_req`, `res_valid` and `flt_align` are low. `op_ready` is low while a request is in flight. A pending result holds all its fields stable while `res_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand request valid |
| op_ready | output | 1 | Unit idle and able to take a request |
| op_insn | input | 32 | Instruction word holding mode bits and register fields |
| op_base | input | XLEN | Current base register value |
| op_index | input | XLEN | Current index register value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Bus lock for the exchange |
| mem_addr | output | XLEN | Memory address |
| mem_wdata | output | XLEN | Write data (zero) |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | XLEN | Read data, valid with acknowledge |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes result |
| res_dst_we | output | 1 | Destination register write enable |
| res_dst_reg | output | 5 | Destination register number |
| res_dst_val | output | XLEN | Old memory word |
| res_base_we | output | 1 | Base register write enable |
| res_base_reg | output | 5 | Base register number |
| res_base_val | output | XLEN | Updated base value |
| flt_align | output | 1 | One-cycle alignment fault pulse |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 16-byte alignment boundary and an index scale shift of two. These defaults make the scaled and unscaled index offsets differ in whether they land on a boundary, and they let small negative displacements reach an aligned address. Memory acknowledge latency in the bench model is varied from zero to three cycles, which stretches the locked window and checks that the lock never drops between read and write. Back-pressure on the result port is exercised by holding `res_ready` low for several cycles.

// File: rtl/lcw_pkg.sv
package lcw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_DONE = 3'd3,
    ST_FLT  = 3'd4
  } lcw_state_e;

  typedef struct packed {
    logic disp_sel;   // displacement rather than index
    logic scale_en;   // index shifted before the add
    logic upd_base;   // base register gets the sum
    logic acc_sum;    // access at the sum rather than old base
  } lcw_mode_t;

  localparam int unsigned RF_AW     = 5;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned F_RT_LSB  = 0;
  localparam int unsigned F_M_BIT   = 5;
  localparam int unsigned F_I_BIT   = 12;
  localparam int unsigned F_A_BIT   = 13;
  localparam int unsigned F_X_LSB   = 16;
  localparam int unsigned F_RB_LSB  = 21;

endpackage

// File: rtl/lcw_addr_gen.sv
module lcw_addr_gen
  import lcw_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned DISP_W   = 5,
  parameter int unsigned SCALE_SH = 2,
  parameter int unsigned ALIGN_LG = 4
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   index,
  output lcw_mode_t         mode,
  output logic [XLEN-1:0]   acc_addr,
  output logic [XLEN-1:0]   new_base,
  output logic              misalign
);

  localparam int unsigned EXT_W = XLEN - DISP_W;

  logic [DISP_W-1:0] disp_fld;
  logic [XLEN-1:0]   disp_ext;
  logic [XLEN-1:0]   idx_off;
  logic [XLEN-1:0]   offset;
  logic [XLEN-1:0]   sum;
  logic              m_bit;
  logic              a_bit;

  assign disp_fld = insn[F_X_LSB +: DISP_W];
  assign disp_ext = {{EXT_W{disp_fld[DISP_W-1]}}, disp_fld};
  assign m_bit    = insn[F_M_BIT];
  assign a_bit    = insn[F_A_BIT];

  always_comb begin
    mode.disp_sel = insn[F_I_BIT];
    mode.upd_base = m_bit;
    if (insn[F_I_BIT]) begin
      mode.scale_en = 1'b0;
      mode.acc_sum  = !(m_bit && !a_bit);
    end else begin
      mode.scale_en = a_bit;
      mode.acc_sum  = !m_bit;
    end
  end

  assign idx_off  = mode.scale_en ? (index << SCALE_SH) : index;
  assign offset   = mode.disp_sel ? disp_ext : idx_off;
  assign sum      = base + offset;
  assign acc_addr = mode.acc_sum ? sum : base;
  assign new_base = sum;

  generate
    if (ALIGN_LG == 0) begin : g_no_align
      assign misalign = 1'b0;
    end else begin : g_align
      assign misalign = |acc_addr[ALIGN_LG-1:0];
    end
  endgenerate

endmodule

// File: rtl/lcw_ctrl.sv
module lcw_ctrl
  import lcw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  output logic            accept,
  input  logic            misalign,
  input  logic [XLEN-1:0] acc_addr,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_lock,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] old_val,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            flt_pulse
);

  lcw_state_e      state_q, state_d;
  logic [XLEN-1:0] addr_q;
  logic [XLEN-1:0] old_q;

  assign op_ready = (state_q == ST_IDLE);
  assign accept   = op_valid && op_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = misalign ? ST_FLT : ST_RD;
      ST_RD:   if (mem_ack) state_d = ST_WR;
      ST_WR:   if (mem_ack) state_d = ST_DONE;
      ST_DONE: if (res_ready) state_d = ST_IDLE;
      ST_FLT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      old_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= acc_addr;
      if (state_q == ST_RD && mem_ack) old_q <= mem_rdata;
    end
  end

  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_lock  = mem_req;
  assign mem_addr  = addr_q;
  assign old_val   = old_q;
  assign res_valid = (state_q == ST_DONE);
  assign flt_pulse = (state_q == ST_FLT);

endmodule

// File: rtl/lcw_wb.sv
module lcw_wb
  import lcw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [RF_AW-1:0] rt,
  input  logic [RF_AW-1:0] rb,
  input  lcw_mode_t        mode,
  input  logic [XLEN-1:0]  new_base,
  output logic             dst_we,
  output logic [RF_AW-1:0] dst_reg,
  output logic             base_we,
  output logic [RF_AW-1:0] base_reg,
  output logic [XLEN-1:0]  base_val
);

  logic dst_we_d;
  logic base_we_d;

  assign dst_we_d  = (rt != '0);
  // the loaded word wins when both writes target one register
  assign base_we_d = mode.upd_base && (rb != '0) && (rb != rt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_we   <= 1'b0;
      dst_reg  <= '0;
      base_we  <= 1'b0;
      base_reg <= '0;
      base_val <= '0;
    end else if (accept) begin
      dst_we   <= dst_we_d;
      dst_reg  <= rt;
      base_we  <= base_we_d;
      base_reg <= rb;
      base_val <= new_base;
    end
  end

endmodule

// File: rtl/lcw_unit.sv
module lcw_unit
  import lcw_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned DISP_W   = 5,
  parameter int unsigned SCALE_SH = 2,
  parameter int unsigned ALIGN_LG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [31:0]      op_insn,
  input  logic [XLEN-1:0]  op_base,
  input  logic [XLEN-1:0]  op_index,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_lock,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic             mem_ack,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_dst_we,
  output logic [4:0]       res_dst_reg,
  output logic [XLEN-1:0]  res_dst_val,
  output logic             res_base_we,
  output logic [4:0]       res_base_reg,
  output logic [XLEN-1:0]  res_base_val,
  output logic             flt_align
);

  lcw_mode_t       mode;
  logic [XLEN-1:0] acc_addr;
  logic [XLEN-1:0] new_base;
  logic            misalign;
  logic            accept;
  logic            insn_unused_bits;

  assign insn_unused_bits = ^{op_insn[31:26], op_insn[15:14], op_insn[11:6]};

  lcw_addr_gen #(
    .XLEN    (XLEN),
    .DISP_W  (DISP_W),
    .SCALE_SH(SCALE_SH),
    .ALIGN_LG(ALIGN_LG)
  ) agen_i (
    .insn    (op_insn),
    .base    (op_base),
    .index   (op_index),
    .mode    (mode),
    .acc_addr(acc_addr),
    .new_base(new_base),
    .misalign(misalign)
  );

  lcw_ctrl #(.XLEN(XLEN)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .accept   (accept),
    .misalign (misalign),
    .acc_addr (acc_addr),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_lock (mem_lock),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .old_val  (res_dst_val),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .flt_pulse(flt_align)
  );

  lcw_wb #(.XLEN(XLEN)) wb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .rt      (op_insn[F_RT_LSB +: RF_AW]),
    .rb      (op_insn[F_RB_LSB +: RF_AW]),
    .mode    (mode),
    .new_base(new_base),
    .dst_we  (res_dst_we),
    .dst_reg (res_dst_reg),
    .base_we (res_base_we),
    .base_reg(res_base_reg),
    .base_val(res_base_val)
  );

  assign mem_wdata = '0;

endmodule

// File: rtl/lcw_unit_chk.sv
module lcw_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_lock,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_ack,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_dst_we,
  input logic [4:0]      res_dst_reg,
  input logic [XLEN-1:0] res_dst_val,
  input logic            res_base_we,
  input logic [4:0]      res_base_reg,
  input logic [XLEN-1:0] res_base_val,
  input logic            flt_align
);

  p_req_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  p_wr_follows_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  p_lock_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && !(mem_req && mem_we && mem_ack)) |=> mem_lock);

  p_same_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_lock && $past(mem_lock)) |-> $stable(mem_addr));

  p_flt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_align |=> !flt_align);

  p_flt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_align |-> (!mem_req && !res_valid));

  p_alias_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dst_we && res_base_we) |-> (res_dst_reg != res_base_reg));

  p_no_r0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!(res_dst_we && res_dst_reg == 5'd0) &&
                   !(res_base_we && res_base_reg == 5'd0)));

  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_dst_val) &&
                                   $stable(res_base_val) && $stable(res_dst_we)));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (!mem_lock && !res_valid && !flt_align));

endmodule

bind lcw_unit lcw_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_ready    (op_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_lock    (mem_lock),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_dst_we  (res_dst_we),
  .res_dst_reg (res_dst_reg),
  .res_dst_val (res_dst_val),
  .res_base_we (res_base_we),
  .res_base_reg(res_base_reg),
  .res_base_val(res_base_val),
  .flt_align   (flt_align)
);

// File: tb/lcw_unit_tb_top.sv
`timescale 1ns/1ps
module lcw_unit_tb_top;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic            op_ready;
  logic [31:0]     op_insn = '0;
  logic [XLEN-1:0] op_base = '0;
  logic [XLEN-1:0] op_index = '0;
  logic            mem_req, mem_we, mem_lock;
  logic [XLEN-1:0] mem_addr, mem_wdata;
  logic            mem_ack = 1'b0;
  logic [XLEN-1:0] mem_rdata = '0;
  logic            res_valid;
  logic            res_ready = 1'b1;
  logic            res_dst_we, res_base_we;
  logic [4:0]      res_dst_reg, res_base_reg;
  logic [XLEN-1:0] res_dst_val, res_base_val;
  logic            flt_align;

  int n_cmp = 0;
  int n_mis = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  lcw_unit #(.XLEN(XLEN)) dut_i (.*);

  // memory model with programmable latency, plus bus monitor
  logic [31:0] mem [64];
  int lat = 0;
  int wait_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0, lock_viol = 0, wr_addr_bad = 0;
  bit in_xchg = 0;
  logic [XLEN-1:0] rd_addr = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req && !mem_lock) lock_viol <= lock_viol + 1;
    if (in_xchg && !mem_lock) lock_viol <= lock_viol + 1;
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt <= 0;
        mem_ack  <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[7:2]] <= mem_wdata;
          wr_cnt  <= wr_cnt + 1;
          in_xchg <= 1'b0;
          if (mem_addr !== rd_addr) wr_addr_bad <= wr_addr_bad + 1;
        end else begin
          mem_rdata <= mem[mem_addr[7:2]];
          rd_cnt  <= rd_cnt + 1;
          in_xchg <= 1'b1;
          rd_addr <= mem_addr;
        end
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] rb,
                                     input logic [4:0] x, input bit i, input bit a,
                                     input bit m);
    return {6'h03, rb, x, 2'b00, a, i, 6'b000111, m, rt};
  endfunction

  // captured outcome of the last request
  bit          g_res;
  int          g_flt;
  bit          g_dwe, g_bwe;
  logic [4:0]  g_dreg, g_breg;
  logic [31:0] g_dval, g_bval;
  int          g_rd0, g_wr0;

  task automatic run_op(input logic [31:0] insn, input logic [31:0] base,
                        input logic [31:0] idx, input int hold);
    g_res = 0; g_flt = 0;
    g_rd0 = rd_cnt; g_wr0 = wr_cnt;
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_insn = insn; op_base = base; op_index = idx; op_valid = 1'b1;
    res_ready = (hold == 0);
    @(negedge clk);
    op_valid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (flt_align) g_flt++;
      if (res_valid) begin
        g_res = 1;
        g_dwe = res_dst_we; g_dreg = res_dst_reg; g_dval = res_dst_val;
        g_bwe = res_base_we; g_breg = res_base_reg; g_bval = res_base_val;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk("R9 result held under back-pressure", {31'd0, res_valid}, 32'd1);
          chk("R9 value stable", res_dst_val, g_dval);
          chk("R9 not ready while busy", {31'd0, op_ready}, 32'd0);
        end
        res_ready = 1'b1;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R9 reset op_ready", {31'd0, op_ready}, 32'd1);
    chk("R9 reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R9 reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R9 reset flt_align", {31'd0, flt_align}, 32'd0);
  endtask

  task automatic t_disp_plain();
    mem[16] = 32'hA5A5_1234; lat = 0;
    run_op(mk(5'd3, 5'd7, 5'd15, 1, 0, 0), 32'h31, 0, 0);  // 0x31+15 = 0x40
    chk("R1 result produced", {31'd0, g_res}, 32'd1);
    chk("R1 old value", g_dval, 32'hA5A5_1234);
    chk("R1 word cleared", mem[16], 32'h0);
    chk("R4 dst reg", {27'd0, g_dreg}, 32'd3);
    chk("R5 no base update", {31'd0, g_bwe}, 32'd0);
    chk("R2 one read", rd_cnt - g_rd0, 1);
    chk("R2 one write", wr_cnt - g_wr0, 1);
  endtask

  task automatic t_disp_pre();
    mem[20] = 32'h0BAD_F00D; lat = 1;
    run_op(mk(5'd4, 5'd9, 5'b10000, 1, 1, 1), 32'h60, 0, 0);  // 0x60-16 = 0x50
    chk("R5 pre-modify old value", g_dval, 32'h0BAD_F00D);
    chk("R5 pre-modify base we", {31'd0, g_bwe}, 32'd1);
    chk("R5 pre-modify base val", g_bval, 32'h50);
    chk("R4 negative disp cleared", mem[20], 32'h0);
  endtask

  task automatic t_disp_post();
    mem[28] = 32'h1111_2222; mem[31] = 32'h7777_7777; lat = 2;
    run_op(mk(5'd6, 5'd8, 5'd15, 1, 0, 1), 32'h70, 0, 0);
    chk("R5 post-modify old value", g_dval, 32'h1111_2222);
    chk("R5 post-modify base val", g_bval, 32'h7F);
    chk("R5 post-modify base reg", {27'd0, g_breg}, 32'd8);
    chk("R5 post-modify other word kept", mem[31], 32'h7777_7777);
  endtask

  task automatic t_idx();
    mem[12] = 32'hCAFE_0001; lat = 0;
    run_op(mk(5'd2, 5'd5, 5'd11, 0, 1, 0), 32'h20, 32'h4, 0);  // 0x20+16
    chk("R6 scaled index old value", g_dval, 32'hCAFE_0001);
    chk("R6 scaled no update", {31'd0, g_bwe}, 32'd0);
    mem[32] = 32'h0000_BEEF; lat = 3;
    run_op(mk(5'd2, 5'd5, 5'd11, 0, 0, 1), 32'h80, 32'h10, 0);
    chk("R6 post index old value", g_dval, 32'h0000_BEEF);
    chk("R6 post index base val", g_bval, 32'h90);
    chk("R6 post index word cleared", mem[32], 32'h0);
  endtask

  task automatic t_misalign();
    mem[17] = 32'h5555_AAAA; lat = 0;
    run_op(mk(5'd3, 5'd7, 5'd0, 1, 0, 0), 32'h44, 0, 0);
    chk("R3 one fault pulse", g_flt, 1);
    chk("R3 no result", {31'd0, g_res}, 32'd0);
    chk("R3 no read", rd_cnt - g_rd0, 0);
    chk("R3 word untouched", mem[17], 32'h5555_AAAA);
    run_op(mk(5'd3, 5'd7, 5'd11, 0, 1, 0), 32'h20, 32'h2, 0);  // 0x28
    chk("R3 scaled index misaligned fault", g_flt, 1);
    chk("R3 scaled index no write", wr_cnt - g_wr0, 0);
  endtask

  task automatic t_alias();
    mem[24] = 32'h1357_9BDF; lat = 1;
    run_op(mk(5'd5, 5'd5, 5'd15, 1, 1, 1), 32'h51, 0, 0);  // 0x60
    chk("R7 dst we", {31'd0, g_dwe}, 32'd1);
    chk("R7 base write dropped", {31'd0, g_bwe}, 32'd0);
    chk("R7 dst keeps old word", g_dval, 32'h1357_9BDF);
  endtask

  task automatic t_r0();
    mem[8] = 32'h2468_ACE0; lat = 0;
    run_op(mk(5'd0, 5'd0, 5'd0, 0, 0, 1), 32'h20, 32'h0, 0);
    chk("R8 no r0 dst write", {31'd0, g_dwe}, 32'd0);
    chk("R8 no r0 base write", {31'd0, g_bwe}, 32'd0);
    chk("R8 word still cleared", mem[8], 32'h0);
  endtask

  task automatic t_backpressure();
    mem[4] = 32'hFEED_0042; lat = 2;
    run_op(mk(5'd9, 5'd1, 5'd0, 1, 0, 0), 32'h10, 0, 4);
    chk("R9 held value", g_dval, 32'hFEED_0042);
    chk("R9 ready after release", {31'd0, op_ready}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disp_plain();
    t_disp_pre();
    t_disp_post();
    t_idx();
    t_misalign();
    t_alias();
    t_r0();
    t_backpressure();
    chk("R2 lock never dropped mid-exchange", lock_viol, 0);
    chk("R2 write at read address", wr_addr_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_cmp++; n_mis++;
    $display("FAIL watchdog R9 actual=%0d expected=<20000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule